// File: doc/BRIEF.md
# Pipelined ROM Fetch Wait-State Controller

This block connects the instruction-fetch port of a processor's tightly-coupled memory to a synchronous ROM whose address and chip-select inputs are registers. Those registers live in this block. They add one pipeline stage between a fetch request and the word the ROM returns. The block hides that stage for sequential fetches with a local +1 incrementer. After each accepted fetch the incrementer loads the predicted next address into the ROM address register. The next sequential request therefore finds its word already on the ROM data lines and completes with no stall.

A nonsequential request pays one stall cycle. The same applies to the first request after reset or after an idle cycle. In the stall cycle the block raises `cpu_wait` and loads the requested address itself into the ROM address register. The requester holds its request through the stall, and the word comes back in the next cycle with `cpu_wait` low. Relative to the requested address, the ROM address lags during a stall. It matches at acceptance and runs one ahead right after an accepted fetch.

The controller is a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No valid prediction. Entered from reset and after any cycle with `cpu_cs` low. |
| `ST_LOAD` | The ROM register holds a freshly loaded stalled address. |
| `ST_STREAM` | The ROM register holds the predicted next sequential address. |

Its transitions are:

| Transition | Condition and effect |
|---|---|
| `GO_IDLE` | From any state when `cpu_cs` is low. |
| `MISS` | To `ST_LOAD` when a request cannot be served at once. This covers a nonsequential request, or any request in `ST_IDLE`. `cpu_wait` is raised. |
| `HIT` | To `ST_STREAM` when a request is served. This covers any request in `ST_LOAD`, or a sequential request in `ST_STREAM`. The ROM address is incremented. |

Top module: `rom_wait_ctrl`

## Requirements
- R1: While reset is asserted, and while `cpu_cs` stays low after it, `rom_cs` is 0, `cpu_wait` is 0 and `cpu_rdata` is 0.
- R2: A request with `cpu_cs`=1 and `cpu_seq`=0 that arrives while the block is streaming drives `cpu_wait` high in that same cycle.
- R3: The first request after reset or after an idle cycle raises `cpu_wait` even when `cpu_seq`=1.
- R4: After a cycle with `cpu_wait` high, `rom_addr` equals the stalled address in the next cycle. The held request then completes in that cycle with `cpu_wait` low, and `cpu_rdata` equals the ROM word at that address.
- R5: A request with `cpu_seq`=1 and address one above the last accepted address, made right after an acceptance, completes with `cpu_wait` low and returns the ROM word at that address.
- R6: At the end of every accepted cycle (`cpu_cs`=1 and `cpu_wait`=0), `rom_addr` becomes its previous value plus one, modulo 2^`ADDR_W`. The address after the top address is 0.
- R7: In a cycle with `cpu_cs` low, `cpu_wait` is 0 and `rom_addr` is unchanged at the next edge.
- R8: `rom_cs` in each cycle equals `cpu_cs` of the previous cycle.
- R9: `cpu_rdata` changes only in accepted cycles. In stall and idle cycles it holds the last returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W (18) | Requested fetch address |
| cpu_cs | input | 1 | Fetch request valid |
| cpu_seq | input | 1 | Request is the previous address plus one |
| cpu_rdata | output | DATA_W (32) | Returned instruction word |
| cpu_wait | output | 1 | Stall: hold the request for another cycle |
| rom_addr | output | ADDR_W (18) | Registered ROM address |
| rom_cs | output | 1 | Registered ROM chip select |
| rom_rdata | input | DATA_W (32) | Word read from the ROM at `rom_addr` |

## Verification
A wrong prediction in the address register shows at the ports in the very cycle of the next sequential fetch. There, `cpu_rdata` carries the word of the wrong address with `cpu_wait` low, so every returned word is compared with a reference computed from the requested address. A state machine stuck in or out of `ST_STREAM` shows as a missing or extra stall on the same request. `rom_addr` and `rom_cs` are sampled one cycle after each stall, acceptance and idle cycle, which exposes a missed load, increment or hold at the next edge. The stimulus mixes random sequential bursts, branches and idle gaps, and directed cases cover the start after reset, the address wrap and back-to-back branches.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_STREAM = 2'd2
    } rwc_state_e;
endpackage

// File: rtl/rwc_fsm.sv
module rwc_fsm
    import rwc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_cs,
    input  logic       cpu_seq,
    output rwc_state_e state,
    output logic       hit,
    output logic       stall
);
    rwc_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        hit      = 1'b0;
        stall    = 1'b0;
        state_nx = state;
        if (!cpu_cs) begin
            state_nx = ST_IDLE;                 // GO_IDLE
        end else begin
            unique case (state)
                ST_IDLE:   begin stall = 1'b1; state_nx = ST_LOAD; end
                ST_LOAD:   begin hit = 1'b1;   state_nx = ST_STREAM; end
                ST_STREAM: begin
                    if (cpu_seq) begin hit = 1'b1;   state_nx = ST_STREAM; end
                    else         begin stall = 1'b1; state_nx = ST_LOAD;   end
                end
                default:   begin stall = 1'b1; state_nx = ST_LOAD; end
            endcase
        end
    end

    // R3: a request straight out of idle always stalls
    a_r3_idle_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_cs) |-> stall);
    // R4: a stall is never followed by a second stall on the held request
    a_r4_one_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!cpu_cs || !stall));
endmodule

// File: rtl/rwc_addr_path.sv
module rwc_addr_path #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cs,
    input  logic              hit,
    input  logic              stall,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_cs
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] addr_inc;
    logic [ADDR_W-1:0] addr_nx;

    assign addr_inc = rom_addr + ONE;

    always_comb begin
        addr_nx = rom_addr;
        if (stall)    addr_nx = cpu_addr;
        else if (hit) addr_nx = addr_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_addr <= '0;
            rom_cs   <= 1'b0;
        end else begin
            rom_addr <= addr_nx;
            rom_cs   <= cpu_cs;
        end
    end

    // R4: a stalled address reaches the ROM register at the next edge
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (rom_addr == $past(cpu_addr)));
    // R6: an accepted fetch advances the ROM address by one
    a_r6_incr: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (rom_addr == $past(rom_addr) + ONE));
endmodule

// File: rtl/rwc_rdata_hold.sv
module rwc_rdata_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [DATA_W-1:0] cpu_rdata
);
    logic [DATA_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   last_q <= '0;
        else if (hit) last_q <= rom_rdata;
    end

    assign cpu_rdata = hit ? rom_rdata : last_q;

    // R9: without an acceptance the returned word holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> $stable(cpu_rdata));
endmodule

// File: rtl/rom_wait_ctrl.sv
module rom_wait_ctrl
    import rwc_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_cs,
    input  logic              cpu_seq,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_wait,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_cs,
    input  logic [DATA_W-1:0] rom_rdata
);
    rwc_state_e state;
    logic       hit;
    logic       stall;

    rwc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_cs  (cpu_cs),
        .cpu_seq (cpu_seq),
        .state   (state),
        .hit     (hit),
        .stall   (stall)
    );

    rwc_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_cs   (cpu_cs),
        .hit      (hit),
        .stall    (stall),
        .cpu_addr (cpu_addr),
        .rom_addr (rom_addr),
        .rom_cs   (rom_cs)
    );

    rwc_rdata_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .rom_rdata (rom_rdata),
        .cpu_rdata (cpu_rdata)
    );

    assign cpu_wait = stall;

    // R2: nonsequential request while streaming stalls
    a_r2_nonseq_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && cpu_cs && !cpu_seq) |-> cpu_wait);
    // R3: first request after an idle cycle stalls
    a_r3_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs && !$past(cpu_cs)) |-> cpu_wait);
    // R7: idle cycles never stall and keep the ROM address
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_cs |-> (!cpu_wait ##1 $stable(rom_addr)));
    // R8: ROM chip select follows the request one cycle later
    a_r8_cs_on: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_cs |=> rom_cs);
    a_r8_cs_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_cs |=> !rom_cs);
    // R8: an accepted fetch always reads with the ROM selected
    a_r8_read_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs && !cpu_wait) |-> rom_cs);
endmodule

// File: tb/rom_wait_ctrl_test.sv
`timescale 1ns/1ps
module rom_wait_ctrl_test;
    localparam int AW = 18;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_cs = 1'b0;
    logic          cpu_seq = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_wait;
    logic [AW-1:0] rom_addr;
    logic          rom_cs;
    logic [DW-1:0] rom_rdata;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic          primed = 1'b0;
    logic [AW-1:0] next_a = '0;
    logic [DW-1:0] last_d = '0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
        logic [DW-1:0] x;
        x = {14'd0, a} * 32'h9E37_79B1;
        return x ^ 32'h5A5A_0000 ^ {a[7:0], 24'd0};
    endfunction

    assign rom_rdata = rom_word(rom_addr);

    rom_wait_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_cs(cpu_cs),
        .cpu_seq(cpu_seq), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
        .rom_addr(rom_addr), .rom_cs(rom_cs), .rom_rdata(rom_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one fetch, driven at the falling edge and sampled 1 ns later
    task automatic fetch(input logic [AW-1:0] a, input logic seq);
        logic exp_wait;
        exp_wait = !(primed && seq && a == next_a);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_addr = a; cpu_seq = seq;
        #1;
        if (seq && primed) check("R5 seq no wait", {63'd0, cpu_wait}, {63'd0, exp_wait});
        else if (!seq)     check("R2 nonseq wait", {63'd0, cpu_wait}, {63'd0, exp_wait});
        else               check("R3 first after idle wait", {63'd0, cpu_wait}, {63'd0, exp_wait});
        if (cpu_wait) begin
            check("R9 hold in stall", {32'd0, cpu_rdata}, {32'd0, last_d});
            @(negedge clk);
            #1;
            check("R4 stalled addr loaded", {46'd0, rom_addr}, {46'd0, a});
            check("R4 wait low after stall", {63'd0, cpu_wait}, 64'd0);
        end
        check(seq ? "R5 data" : "R4 data", {32'd0, cpu_rdata}, {32'd0, rom_word(a)});
        last_d = rom_word(a);
        next_a = a + 1'b1;
        primed = 1'b1;
        @(negedge clk);
        #0;
        check("R6 incr after accept", {46'd0, rom_addr}, {46'd0, next_a});
        check("R8 rom_cs follows", {63'd0, rom_cs}, 64'd1);
    endtask

    // fetch leaves inputs asserted into the next cycle; callers go on at once
    task automatic idle_cycle();
        logic [AW-1:0] held;
        cpu_cs = 1'b0; cpu_seq = 1'b0;
        #1;
        held = rom_addr;
        check("R7 idle no wait", {63'd0, cpu_wait}, 64'd0);
        check("R9 idle hold", {32'd0, cpu_rdata}, {32'd0, last_d});
        @(negedge clk);
        check("R7 idle addr held", {46'd0, rom_addr}, {46'd0, held});
        check("R8 rom_cs low", {63'd0, rom_cs}, 64'd0);
        primed = 1'b0;
    endtask

    // after fetch returns we are just past a falling edge with the request still driven;
    // the request of the next fetch replaces it in that same low phase
    task automatic fetch_now(input logic [AW-1:0] a, input logic seq);
        logic exp_wait;
        exp_wait = !(primed && seq && a == next_a);
        cpu_cs = 1'b1; cpu_addr = a; cpu_seq = seq;
        #1;
        if (!seq) check("R2 nonseq wait", {63'd0, cpu_wait}, {63'd0, exp_wait});
        else      check("R5 seq no wait", {63'd0, cpu_wait}, {63'd0, exp_wait});
        if (cpu_wait) begin
            check("R9 hold in stall", {32'd0, cpu_rdata}, {32'd0, last_d});
            @(negedge clk);
            #1;
            check("R4 stalled addr loaded", {46'd0, rom_addr}, {46'd0, a});
            check("R4 wait low after stall", {63'd0, cpu_wait}, 64'd0);
        end
        check(seq ? "R5 data" : "R4 data", {32'd0, cpu_rdata}, {32'd0, rom_word(a)});
        last_d = rom_word(a);
        next_a = a + 1'b1;
        primed = 1'b1;
        @(negedge clk);
        check("R6 incr after accept", {46'd0, rom_addr}, {46'd0, next_a});
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset rom_cs", {63'd0, rom_cs}, 64'd0);
        check("R1 reset wait", {63'd0, cpu_wait}, 64'd0);
        check("R1 reset rdata", {32'd0, cpu_rdata}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 idle after reset wait", {63'd0, cpu_wait}, 64'd0);
        check("R1 idle after reset rom_cs", {63'd0, rom_cs}, 64'd0);

        // directed: sequential flag on the very first request still stalls
        fetch(18'h00100, 1'b1);
        fetch_now(18'h00101, 1'b1);
        fetch_now(18'h00102, 1'b1);
        // back-to-back branches
        fetch_now(18'h02000, 1'b0);
        fetch_now(18'h00050, 1'b0);
        fetch_now(18'h00051, 1'b1);
        idle_cycle();
        // wrap at the top address
        fetch_now(18'h3FFFE, 1'b0);
        fetch_now(18'h3FFFF, 1'b1);
        fetch_now(18'h00000, 1'b1);
        idle_cycle();
        // after idle, a sequential continuation is still a miss
        fetch_now(18'h00001, 1'b1);

        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 10;
            if (r < 6 && primed) fetch_now(next_a, 1'b1);
            else if (r < 8)      fetch_now(AW'($urandom), 1'b0);
            else                 idle_cycle();
        end
        idle_cycle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule